// File: doc/BRIEF.md
# Phase Slope Limiter with Bandwidth Select

This block sits in a digital PLL between the phase detector and a first-order loop filter. On every update tick it takes one signed phase-error sample and clamps it to a symmetric maximum step. This bounds how far the corrected phase can move per tick, so any input transient gives a bounded output phase slope.

The block also picks the loop-filter gain setting. The choice depends on a bandwidth-select input and on the class of reference frequency that was detected. The same decision sets the step limit. A narrow setting gives a slow slope limit of about 61 µs/s. The two wide settings share a fast limit of about 9.5 ms/s. Each of these limits is given as a per-tick step by a parameter.

The block outputs the limited error and a coefficient-select code for the filter. It also outputs the unlimited error on a separate tap for a lock indicator. All outputs are registered and come with a one-cycle valid strobe.

Top module: `slope_limiter`

## Requirements
- R1: With `bw_wide_i` low, `coef_sel_o` is 0 (narrow) and the step limit is `NARROW_STEP`, for every value of `ref_class_i`.
- R2: With `bw_wide_i` high and `ref_class_i` = 0 (8 kHz), `coef_sel_o` is 1 (medium) and the step limit is `WIDE_STEP`.
- R3: With `bw_wide_i` high and `ref_class_i` in 1..4 (the four MHz rates), `coef_sel_o` is 2 (wide) and the step limit is `WIDE_STEP`.
- R4: With `bw_wide_i` high and `ref_class_i` in 5..7 (invalid), `coef_sel_o` is 0 and the step limit is `NARROW_STEP`.
- R5: An error whose magnitude is at most the selected step appears unchanged on `lim_err_o`. This includes exactly +step and -step.
- R6: An error above +step gives +step, and an error below -step gives -step. This includes the most negative input value.
- R7: `err_tap_o` carries the unlimited input error of the same tick.
- R8: `valid_o` is high for exactly the cycle after each cycle in which `tick_i` is high. Back-to-back ticks give back-to-back results. In cycles without a tick, the data outputs hold their value.
- R9: While reset is asserted, `valid_o`, `lim_err_o`, `err_tap_o` and `coef_sel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Update strobe; samples the inputs |
| err_i | input | ERR_W | Signed phase error from the detector |
| bw_wide_i | input | 1 | Bandwidth select: 0 narrow, 1 wide |
| ref_class_i | input | 3 | Detected reference class: 0 = 8 kHz, 1..4 = MHz rates, 5..7 invalid |
| valid_o | output | 1 | Result strobe, one cycle after a tick |
| lim_err_o | output | ERR_W | Limited signed error to the loop filter |
| err_tap_o | output | ERR_W | Unlimited error for the lock indicator |
| coef_sel_o | output | 2 | Filter coefficient select: 0 narrow, 1 medium, 2 wide |

## Verification
The bench sweeps every reference class with the bandwidth select low and high. This separates the three coefficient codes and shows that invalid classes fall back to the narrow setting. For each setting the error is driven inside the limit, exactly at ±step, one count beyond it, and at the full-scale extremes. This separates the pass-through path from the clamp and shows which of the two step limits is in force. Back-to-back ticks followed by idle gaps show the one-cycle latency and that the outputs hold between ticks.

// File: rtl/slope_lim_pkg.sv
package slope_lim_pkg;
  typedef enum logic [1:0] {
    COEF_NARROW = 2'd0,
    COEF_MID    = 2'd1,
    COEF_WIDE   = 2'd2
  } coef_sel_e;

  localparam logic [2:0] REF_8K      = 3'd0;
  localparam logic [2:0] REF_MHZ_LO  = 3'd1;
  localparam logic [2:0] REF_MHZ_HI  = 3'd4;
endpackage

// File: rtl/bw_select.sv
module bw_select
  import slope_lim_pkg::*;
(
  input  logic       bw_wide_i,
  input  logic [2:0] ref_class_i,
  output coef_sel_e  coef_o,
  output logic       fast_slope_o
);
  always_comb begin
    coef_o       = COEF_NARROW;
    fast_slope_o = 1'b0;
    if (bw_wide_i) begin
      if (ref_class_i == REF_8K) begin
        coef_o       = COEF_MID;
        fast_slope_o = 1'b1;
      end else if (ref_class_i >= REF_MHZ_LO && ref_class_i <= REF_MHZ_HI) begin
        coef_o       = COEF_WIDE;
        fast_slope_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sym_clamp.sv
module sym_clamp #(
  parameter int ERR_W = 16
) (
  input  logic signed [ERR_W-1:0] err_i,
  input  logic signed [ERR_W-1:0] step_i,
  output logic signed [ERR_W-1:0] lim_o
);
  logic signed [ERR_W-1:0] neg_step;
  assign neg_step = -step_i;

  always_comb begin
    if (err_i > step_i)         lim_o = step_i;
    else if (err_i < neg_step)  lim_o = neg_step;
    else                        lim_o = err_i;
  end
endmodule

// File: rtl/slope_limiter.sv
module slope_limiter
  import slope_lim_pkg::*;
#(
  parameter int ERR_W       = 16,
  parameter int NARROW_STEP = 3,
  parameter int WIDE_STEP   = 500
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    bw_wide_i,
  input  logic [2:0]              ref_class_i,
  output logic                    valid_o,
  output logic signed [ERR_W-1:0] lim_err_o,
  output logic signed [ERR_W-1:0] err_tap_o,
  output logic [1:0]              coef_sel_o
);
  localparam logic signed [ERR_W-1:0] NARROW_S = ERR_W'(NARROW_STEP);
  localparam logic signed [ERR_W-1:0] WIDE_S   = ERR_W'(WIDE_STEP);

  coef_sel_e               coef_d;
  logic                    fast_slope;
  logic signed [ERR_W-1:0] step_d;
  logic signed [ERR_W-1:0] lim_d;

  bw_select i_bw_select (
    .bw_wide_i   (bw_wide_i),
    .ref_class_i (ref_class_i),
    .coef_o      (coef_d),
    .fast_slope_o(fast_slope)
  );

  assign step_d = fast_slope ? WIDE_S : NARROW_S;

  sym_clamp #(.ERR_W(ERR_W)) i_sym_clamp (
    .err_i (err_i),
    .step_i(step_d),
    .lim_o (lim_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      lim_err_o  <= '0;
      err_tap_o  <= '0;
      coef_sel_o <= COEF_NARROW;
    end else begin
      valid_o <= tick_i;
      if (tick_i) begin
        lim_err_o  <= lim_d;
        err_tap_o  <= err_i;
        coef_sel_o <= coef_d;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(tick_i)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(lim_err_o) && $stable(coef_sel_o)); // R8
  AST_NARROW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_sel_o == COEF_NARROW) |-> (lim_err_o <= NARROW_S && lim_err_o >= -NARROW_S)); // R1
  AST_WIDE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_sel_o != COEF_NARROW) |-> (lim_err_o <= WIDE_S && lim_err_o >= -WIDE_S)); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_sel_o != 2'd3); // R4
  AST_TAP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_tap_o <= NARROW_S && err_tap_o >= -NARROW_S) |-> lim_err_o == err_tap_o); // R5
endmodule

// File: tb/test_slope_limiter.sv
module test_slope_limiter;
  localparam int ERR_W = 16;
  localparam int NS    = 3;
  localparam int WS    = 500;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    tick_i = 1'b0;
  logic signed [ERR_W-1:0] err_i = '0;
  logic                    bw_wide_i = 1'b0;
  logic [2:0]              ref_class_i = '0;
  logic                    valid_o;
  logic signed [ERR_W-1:0] lim_err_o;
  logic signed [ERR_W-1:0] err_tap_o;
  logic [1:0]              coef_sel_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct {
    int    lim;
    int    tap;
    int    coef;
    string tag;
  } exp_t;
  exp_t sb[$];
  int last_lim  = 0;
  int last_coef = 0;

  always #10 clk_i = ~clk_i;

  slope_limiter #(.ERR_W(ERR_W), .NARROW_STEP(NS), .WIDE_STEP(WS)) i_slope_limiter (
    .clk_i, .rst_ni, .tick_i, .err_i, .bw_wide_i, .ref_class_i,
    .valid_o, .lim_err_o, .err_tap_o, .coef_sel_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit bw, input int cls, input int err, input string tag);
    exp_t e;
    int coef, step;
    @(negedge clk_i);
    bw_wide_i   = bw;
    ref_class_i = 3'(cls);
    err_i       = ERR_W'(err);
    tick_i      = 1'b1;
    if (!bw || cls > 4)  begin coef = 0; step = NS; end
    else if (cls == 0)   begin coef = 1; step = WS; end
    else                 begin coef = 2; step = WS; end
    e.lim  = err > step ? step : (err < -step ? -step : err);
    e.tap  = err;
    e.coef = coef;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b0;
      err_i  = 16'sh7abc;
      bw_wide_i   = ~bw_wide_i;
      ref_class_i = ref_class_i + 3'd1;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(int'(lim_err_o) == e.lim, {e.tag, " lim"}, int'(lim_err_o), e.lim);
          chk(int'(err_tap_o) == e.tap, "R7 tap", int'(err_tap_o), e.tap);
          chk(int'(coef_sel_o) == e.coef, {e.tag, " coef"}, int'(coef_sel_o), e.coef);
          last_lim  = e.lim;
          last_coef = e.coef;
        end
      end else begin
        chk(int'(lim_err_o) == last_lim && int'(coef_sel_o) == last_coef,
            "R8 hold", int'(lim_err_o), last_lim);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R9 valid", int'(valid_o), 0);
    chk(lim_err_o == '0, "R9 lim", int'(lim_err_o), 0);
    chk(err_tap_o == '0, "R9 tap", int'(err_tap_o), 0);
    chk(coef_sel_o == 2'd0, "R9 coef", int'(coef_sel_o), 0);
    rst_ni = 1'b1;
    idle(2);

    // R1: narrow for every class
    for (int c = 0; c < 8; c++) send(1'b0, c, 100, "R1");
    send(1'b0, 2, -100, "R1");
    send(1'b0, 0, 3, "R5");
    send(1'b0, 0, -3, "R5");
    send(1'b0, 0, 4, "R6");
    send(1'b0, 0, -4, "R6");
    idle(3);

    // R2
    send(1'b1, 0, 1000, "R2");
    send(1'b1, 0, -1000, "R2");
    send(1'b1, 0, 499, "R5");
    send(1'b1, 0, 500, "R5");
    send(1'b1, 0, 501, "R6");
    idle(2);

    // R3
    for (int c = 1; c <= 4; c++) send(1'b1, c, -32768, "R3");
    send(1'b1, 3, 32767, "R6");
    send(1'b1, 4, -500, "R5");
    send(1'b1, 1, -501, "R6");
    idle(4);

    // R4
    for (int c = 5; c < 8; c++) send(1'b1, c, 10, "R4");
    send(1'b1, 6, -2, "R5");
    send(1'b1, 7, -32768, "R6");
    idle(3);

    // isolated tick after gap
    send(1'b1, 2, 7, "R8");
    idle(5);

    chk(sb.size() == 0, "R8 drained", sb.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule